// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer for 18-bit words. It has one write port and one read port, each with its own clock. Each port has an active-low enable. The two clocks may run independently or be driven from the same source. Depth is a power-of-two parameter with a default of 16. The write pointer and the read pointer cross between the domains as Gray-coded values through two-flop synchronizers. Each pointer carries one wrap bit beyond the address, so a full buffer and an empty buffer give different pointer values.

The block reports its fill level on five active-low status outputs: empty, almost-empty, half-full, almost-full and full. The two almost thresholds come from offset input ports. A mode input selects how the two almost flags are produced. They are either registered in their own clock domain, or decoded combinationally from the raw pointer difference. A retransmit strobe moves the read pointer back to storage location 0, so the words written since reset can be read again.

Control is built from two small state machines, one per clock domain.

- The write side has states `WR_OPEN` and `WR_FULL`.
  - Transition FILL moves from `WR_OPEN` to `WR_FULL` when the next fill level equals the depth.
  - Transition DRAIN moves back to `WR_OPEN` when the next fill level falls below the depth.
- The read side has states `RD_DRY` and `RD_LIVE`.
  - Transition ARRIVE moves from `RD_DRY` to `RD_LIVE` when the next fill level seen by the read side is non-zero.
  - Transition EXHAUST moves back to `RD_DRY` when that level reaches zero.
  - A retransmit re-evaluates the read state from the rewound pointer.

Top module: `dcfifo_pf`

## Requirements
- R1: A word on `din` is stored on a rising `wclk` edge when `wen_n` is low and `full_n` is high. Stored words come out on `dout` in write order, one per rising `rclk` edge on which `ren_n` is low and `empty_n` is high.
- R2: When `full_n` is low, a write request is ignored. Neither the stored data nor the fill level changes.
- R3: When `empty_n` is low, a read request is ignored. `dout` keeps the last word that was validly read.
- R4: `empty_n` is low exactly when the buffer holds zero words. It changes only on rising `rclk` edges.
- R5: `full_n` is low exactly when the buffer holds DEPTH words. It changes only on rising `wclk` edges.
- R6: `hf_n` is low when the fill level is greater than DEPTH/2. It is registered on `wclk`.
- R7: `ae_n` is low when the fill level is less than or equal to `ae_off`.
- R8: `af_n` is low when the fill level is greater than or equal to DEPTH minus `af_off`.
- R9: The mode input `flag_sync` selects how `ae_n` and `af_n` are produced.
  - With `flag_sync` at 1, `ae_n` is registered on `rclk` and `af_n` on `wclk`. Both then lag pointer moves from the other domain by the synchronizer delay.
  - With `flag_sync` at 0, both are decoded combinationally from the current write and read pointers. A write is therefore visible on `ae_n` before the next edge.
- R10: While `rst_n` is low, the outputs hold the empty condition: `empty_n`=0, `ae_n`=0, `hf_n`=1, `af_n`=1, `full_n`=1 and `dout`=0.
- R11: `rt` is sampled high on a rising `rclk` edge. It sets the read pointer to location 0, and any read request on that edge is dropped. Later reads replay the words written since reset, in order, until the read pointer meets the write pointer. The flags follow the new pointer positions.
- R12: After a write to an empty buffer, a read issued in the first read cycle where `empty_n` is high returns that word on `dout` at the next rising `rclk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| wen_n | input | 1 | Active-low write request |
| din | input | DW (18) | Write data |
| ren_n | input | 1 | Active-low read request |
| rt | input | 1 | Retransmit strobe, active high, read domain |
| flag_sync | input | 1 | 1: almost flags registered; 0: almost flags decoded combinationally |
| ae_off | input | PW (5) | Almost-empty offset in words |
| af_off | input | PW (5) | Almost-full offset in words |
| dout | output | DW (18) | Read data register |
| empty_n | output | 1 | Low when no words are held |
| ae_n | output | 1 | Low when almost empty |
| hf_n | output | 1 | Low when more than half full |
| af_n | output | 1 | Low when almost full |
| full_n | output | 1 | Low when DEPTH words are held |

## Verification
The assertions assume the following about the inputs:

- The retransmit strobe is never raised together with a read request.
- The total number of words written since reset never exceeds the depth when a retransmit is used.
- The write pointer is never more than DEPTH words ahead of the read pointer as seen by the write side.

The stimulus keeps to these limits. It drives `rt` only while `ren_n` is high. It writes six words before the rewind. It relies on the full flag to stop the overfill burst. Both clocks come from one source, so the bench can wait a fixed settling time after each burst and then compare every flag against the fill level that its own scoreboard holds.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    typedef enum logic {
        WR_OPEN = 1'b0,
        WR_FULL = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_DRY  = 1'b0,
        RD_LIVE = 1'b1
    } rd_state_e;

endpackage

// File: rtl/dcfifo_ptr_sync.sv
`timescale 1ns/1ps
module dcfifo_ptr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= gray_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    // Gray to binary conversion of the last stage
    always_comb begin
        bin_out[W-1] = chain[STAGES-1][W-1];
        for (int i = W-2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ chain[STAGES-1][i];
        end
    end
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic [PW-1:0] rbin_sync,
    input  logic [PW-1:0] af_off,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          full_n,
    output logic          af_reg_n,
    output logic          hf_n
);
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2);
    localparam logic [PW:0]   DEPTH_E = (PW+1)'(DEPTH);

    wr_state_e     st_q, st_d;
    logic [PW-1:0] wbin_q, wbin_d, wgray_q, cnt_d;
    logic          af_q, hf_q, do_wr;

    assign do_wr  = !wen_n && (st_q == WR_OPEN);
    assign wbin_d = wbin_q + PW'(do_wr);
    assign cnt_d  = wbin_d - rbin_sync;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_OPEN: if (cnt_d == DEPTH_V) st_d = WR_FULL;   // FILL
            WR_FULL: if (cnt_d != DEPTH_V) st_d = WR_OPEN;   // DRAIN
        endcase
    end

    // State register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= WR_OPEN;
        else        st_q <= st_d;
    end

    // Pointer and registered flags
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            af_q    <= 1'b1;
            hf_q    <= 1'b1;
        end else begin
            wbin_q  <= wbin_d;
            wgray_q <= wbin_d ^ (wbin_d >> 1);
            af_q    <= !(({1'b0, cnt_d} + {1'b0, af_off}) >= DEPTH_E);
            hf_q    <= !(cnt_d > HALF_V);
        end
    end

    // Outputs
    always_comb begin
        we       = do_wr;
        waddr    = wbin_q[AW-1:0];
        wbin     = wbin_q;
        wgray    = wgray_q;
        full_n   = (st_q != WR_FULL);
        af_reg_n = af_q;
        hf_n     = hf_q;
    end

    // R2: a request while full leaves the write pointer where it was
    p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (st_q == WR_FULL && !wen_n) |=> $stable(wbin_q));

    // R5: the write side never sees more than DEPTH words outstanding
    p_fill_bound_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        (PW'(wbin_q - rbin_sync) <= DEPTH_V));
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4,
    parameter int PW = 5
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic          rt,
    input  logic [PW-1:0] wbin_sync,
    input  logic [PW-1:0] ae_off,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty_n,
    output logic          ae_reg_n,
    output logic [DW-1:0] dout
);
    rd_state_e     st_q, st_d;
    logic [PW-1:0] rbin_q, rbin_d, rgray_q, cnt_d;
    logic [DW-1:0] dout_q;
    logic          ae_q, do_rd;

    assign do_rd  = !ren_n && (st_q == RD_LIVE) && !rt;
    assign rbin_d = rt ? '0 : rbin_q + PW'(do_rd);
    assign cnt_d  = wbin_sync - rbin_d;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_DRY:  if (cnt_d != '0) st_d = RD_LIVE;  // ARRIVE
            RD_LIVE: if (cnt_d == '0) st_d = RD_DRY;   // EXHAUST
        endcase
    end

    // State register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_DRY;
        else        st_q <= st_d;
    end

    // Pointer, data register and registered flag
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            ae_q    <= 1'b0;
            dout_q  <= '0;
        end else begin
            rbin_q  <= rbin_d;
            rgray_q <= rbin_d ^ (rbin_d >> 1);
            ae_q    <= !(cnt_d <= ae_off);
            if (do_rd) dout_q <= rdata;
        end
    end

    // Outputs
    always_comb begin
        raddr    = rbin_q[AW-1:0];
        rbin     = rbin_q;
        rgray    = rgray_q;
        empty_n  = (st_q == RD_LIVE);
        ae_reg_n = ae_q;
        dout     = dout_q;
    end

    // R3: a request while empty leaves the output word unchanged
    p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q == RD_DRY && !ren_n) |=> $stable(dout_q));

    // R11: a retransmit strobe rewinds the read pointer to location 0
    p_rewind_r11: assert property (@(posedge rclk) disable iff (!rst_n)
        rt |=> (rbin_q == '0));

    // R4: the live state implies the read side sees unread words
    p_live_has_data_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q == RD_LIVE) |-> (wbin_sync != rbin_q));

    // R10: reset holds the empty condition and a cleared output
    always @(posedge rclk) begin
        if (!rst_n) begin
            p_reset_state_r10: assert (dout_q == '0 && st_q == RD_DRY);
        end
    end
endmodule

// File: rtl/dcfifo_pf.sv
`timescale 1ns/1ps
module dcfifo_pf #(
    parameter int DEPTH       = 16,
    parameter int DW          = 18,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = $clog2(DEPTH),
    parameter int PW          = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    input  logic          ren_n,
    input  logic          rt,
    input  logic          flag_sync,
    input  logic [PW-1:0] ae_off,
    input  logic [PW-1:0] af_off,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          ae_n,
    output logic          hf_n,
    output logic          af_n,
    output logic          full_n
);
    localparam logic [PW:0] DEPTH_E = (PW+1)'(DEPTH);

    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rdata;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wbin_in_r, rbin_in_w, raw_cnt;
    logic          af_reg_n, ae_reg_n;

    dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    dcfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rbin_in_w)
    );

    dcfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wbin_in_r)
    );

    dcfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wen_n     (wen_n),
        .rbin_sync (rbin_in_w),
        .af_off    (af_off),
        .we        (we),
        .waddr     (waddr),
        .wbin      (wbin),
        .wgray     (wgray),
        .full_n    (full_n),
        .af_reg_n  (af_reg_n),
        .hf_n      (hf_n)
    );

    dcfifo_rd_ctl #(.DW(DW), .AW(AW), .PW(PW)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .ren_n     (ren_n),
        .rt        (rt),
        .wbin_sync (wbin_in_r),
        .ae_off    (ae_off),
        .rdata     (rdata),
        .raddr     (raddr),
        .rbin      (rbin),
        .rgray     (rgray),
        .empty_n   (empty_n),
        .ae_reg_n  (ae_reg_n),
        .dout      (dout)
    );

    // Almost flags: registered per domain, or decoded from the raw pointer gap
    assign raw_cnt = wbin - rbin;

    always_comb begin
        if (flag_sync) begin
            ae_n = ae_reg_n;
            af_n = af_reg_n;
        end else begin
            ae_n = !(raw_cnt <= ae_off);
            af_n = !(({1'b0, raw_cnt} + {1'b0, af_off}) >= DEPTH_E);
        end
    end

    // R5/R8: in registered mode, full implies almost-full on the write clock
    p_full_in_af_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        (flag_sync && !full_n) |-> !af_reg_n);
endmodule

// File: tb/dcfifo_pf_tb.sv
`timescale 1ns/1ps
module dcfifo_pf_tb;
    localparam int DEPTH = 16;
    localparam int DW    = 18;
    localparam int PW    = 5;
    localparam int AEO   = 3;
    localparam int AFO   = 4;

    logic          clk = 1'b0;
    logic          rst_n, wen_n, ren_n, rt, flag_sync;
    logic [DW-1:0] din;
    logic [PW-1:0] ae_off, af_off;
    logic [DW-1:0] dout;
    logic          empty_n, ae_n, hf_n, af_n, full_n;

    int nvec = 0;
    int nerr = 0;
    int dval = 1;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] hist[$];
    logic          rd_hit = 1'b0;

    always #4 clk = ~clk;

    dcfifo_pf #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .wclk (clk), .rclk (clk), .rst_n (rst_n),
        .wen_n (wen_n), .din (din), .ren_n (ren_n), .rt (rt),
        .flag_sync (flag_sync), .ae_off (ae_off), .af_off (af_off),
        .dout (dout), .empty_n (empty_n), .ae_n (ae_n), .hf_n (hf_n),
        .af_n (af_n), .full_n (full_n)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Scoreboard driver side: accepted writes, rewinds and reads at the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_hit <= 1'b0;
        end else begin
            if (!wen_n && full_n) begin
                exp_q.push_back(din);
                hist.push_back(din);
            end
            if (rt) exp_q = hist;
            rd_hit <= !ren_n && empty_n && !rt;
        end
    end

    // Scoreboard monitor: compare each read result away from the edge (R1)
    always @(negedge clk) begin
        if (rd_hit) begin
            if (exp_q.size() == 0) begin
                nvec++; nerr++;
                $display("FAIL R1: read returned %0h with nothing expected", dout);
            end else begin
                check("R1 data order", 32'(dout), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic check_flags(input string ctx);
        int c;
        c = exp_q.size();
        check({"R4 empty ", ctx}, 32'(empty_n), 32'(c != 0));
        check({"R7 almost-empty ", ctx}, 32'(ae_n), 32'(!(c <= AEO)));
        check({"R6 half-full ", ctx}, 32'(hf_n), 32'(!(c > DEPTH/2)));
        check({"R8 almost-full ", ctx}, 32'(af_n), 32'(!(c >= DEPTH - AFO)));
        check({"R5 full ", ctx}, 32'(full_n), 32'(c != DEPTH));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; rt = 1'b0;
        flag_sync = mode; din = '0;
        idle(3);
        exp_q.delete(); hist.delete();
        check("R10 empty_n", 32'(empty_n), 32'd0);
        check("R10 ae_n", 32'(ae_n), 32'd0);
        check("R10 hf_n", 32'(hf_n), 32'd1);
        check("R10 af_n", 32'(af_n), 32'd1);
        check("R10 full_n", 32'(full_n), 32'd1);
        check("R10 dout", 32'(dout), 32'd0);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic wr(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wen_n = 1'b0; din = DW'(dval); dval++;
        end
        @(negedge clk);
        wen_n = 1'b1;
    endtask

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ren_n = 1'b0;
        end
        @(negedge clk);
        ren_n = 1'b1;
    endtask

    task automatic run_levels(input logic mode);
        string m;
        logic [DW-1:0] last;
        m = mode ? "sync" : "async";
        do_reset(mode);
        check_flags({m, " c0"});
        wr(2); idle(8); check_flags({m, " c2"});
        wr(1); idle(8); check_flags({m, " c3"});
        wr(1); idle(8); check_flags({m, " c4"});
        wr(4); idle(8); check_flags({m, " c8"});
        wr(1); idle(8); check_flags({m, " c9"});
        wr(2); idle(8); check_flags({m, " c11"});
        wr(1); idle(8); check_flags({m, " c12"});
        wr(4); idle(8); check_flags({m, " c16"});
        wr(3); idle(8); check_flags({m, " R2 overfill"});
        check("R2 words held", 32'(exp_q.size()), 32'(DEPTH));
        rd(5);  idle(8); check_flags({m, " c11 after reads"});
        rd(11); idle(8); check_flags({m, " drained"});
        last = dout;
        rd(3); idle(4);
        check("R3 dout held when empty", 32'(dout), 32'(last));
        check("R3 still empty", 32'(empty_n), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; rt = 1'b0;
        flag_sync = 1'b1; din = '0;
        ae_off = PW'(AEO); af_off = PW'(AFO);

        run_levels(1'b1);
        run_levels(1'b0);

        // R9: combinational almost-empty follows a write before the next edge
        do_reset(1'b0);
        wr(3); idle(8);
        @(negedge clk); wen_n = 1'b0; din = DW'(dval); dval++;
        @(negedge clk); wen_n = 1'b1;
        check("R9 async ae_n immediate", 32'(ae_n), 32'd1);
        idle(8); check_flags("R9 async settled");

        // R9: registered almost-empty lags the write by the synchronizer
        do_reset(1'b1);
        wr(3); idle(8);
        @(negedge clk); wen_n = 1'b0; din = DW'(dval); dval++;
        @(negedge clk); wen_n = 1'b1;
        check("R9 sync ae_n lags", 32'(ae_n), 32'd0);
        idle(8); check_flags("R9 sync settled");
        rd(4); idle(8);

        // R12: first word is returned by the first read after empty clears
        begin
            logic [DW-1:0] first;
            do_reset(1'b1);
            first = DW'(dval);
            wr(1);
            for (int k = 0; k < 12; k++) begin
                if (empty_n) break;
                @(negedge clk);
            end
            ren_n = 1'b0;
            @(negedge clk); ren_n = 1'b1;
            check("R12 first word", 32'(dout), 32'(first));
            idle(8); check_flags("R12 after read");
        end

        // R11: rewind and replay of everything written since reset
        do_reset(1'b1);
        wr(6); idle(8);
        rd(3); idle(8); check_flags("R11 before rewind");
        @(negedge clk); rt = 1'b1;
        @(negedge clk); rt = 1'b0;
        idle(8);
        check("R11 words after rewind", 32'(exp_q.size()), 32'd6);
        check_flags("R11 after rewind");
        rd(6); idle(8);
        check_flags("R11 replay drained");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule